// File: doc/BRIEF.md
# SPI Master with Mode-Fault Fallback

This block is an SPI controller that runs as bus master under software control. While it is master it watches its slave-select pin for a second master that wants the bus. Software configures it through a small register interface: a master enable, a switch that turns slave-select sensing off, the direction the slave-select pin has been given, and an interrupt flag with its local enable. A global interrupt enable arrives as an input. SCK and MOSI are driven with output enables, and so is MISO.

When sensing is active, the slave-select pin is an input and its synchronised level is low while the block is master, this counts as a mode fault. Hardware then clears the master enable, aborts any byte in flight and drops the partial result. It turns SCK and MOSI into inputs, turns MISO into an output and sets the interrupt flag. The block stays a slave until software writes the master enable back to 1. A single byte shifter serves both modes. As master it generates SCK from a fixed divider. As slave it shifts on the synchronised external SCK while slave-select is low.

Top module: `spi_mf_ctrl`

## Requirements
- R1: After reset the control register (address 0) and the status register (address 1) read 0, sck_oe_o and mosi_oe_o are 0, and irq_o is 0.
- R2: In master mode, a write to the data register (address 2) starts a byte transfer. The transfer is MSB first, with SCK idle low. The block samples MISO on the rising SCK edge and changes MOSI on the falling edge, and each SCK half period lasts DIV_HALF clocks. Status bit 1 is high while the transfer runs, and the received byte is then read back from address 2.
- R3: With control bit 1 (sensing off) set to 1, no level on ss_i changes the master enable or the flag.
- R4: With sensing on and control bit 2 (SS is output) at 0, a high ss_i keeps master operation active.
- R5: With sensing on, SS as input and master enable (control bit 0) at 1, a low ss_i that has passed the two-stage synchroniser clears the master enable and sets the flag (status bit 0).
- R6: irq_o is 1 exactly when the flag, the local enable (control bit 3) and gie_i are all 1.
- R7: With control bit 2 set to 1, the level of ss_i has no effect on master operation.
- R8: In master mode sck_oe_o and mosi_oe_o are 1 and miso_oe_o is 0. In slave mode this is reversed.
- R9: After a fault the block stays a slave until software writes control bit 0 to 1.
- R10: A fault in the middle of a byte ends the transfer in the cycle the master enable clears. SCK returns low, and the data register keeps its previous received byte.
- R11: Writing 1 to status bit 0 clears the flag. If a fault occurs in the same cycle, the flag stays set.
- R12: A data write while the master enable is 0 starts no SCK activity and loads the slave transmit byte. In slave mode, with ss_i low, the block shifts MOSI in on rising sck_i edges and MISO out MSB first on falling sck_i edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | DW | Register write data |
| reg_rdata_o | output | DW | Register read data for reg_addr_i |
| gie_i | input | 1 | Global interrupt enable |
| irq_o | output | 1 | Interrupt request |
| sck_i | input | 1 | SCK pin input level |
| sck_o | output | 1 | SCK driven value |
| sck_oe_o | output | 1 | SCK output enable |
| mosi_i | input | 1 | MOSI pin input level |
| mosi_o | output | 1 | MOSI driven value |
| mosi_oe_o | output | 1 | MOSI output enable |
| miso_i | input | 1 | MISO pin input level |
| miso_o | output | 1 | MISO driven value |
| miso_oe_o | output | 1 | MISO output enable |
| ss_i | input | 1 | Slave-select pin input level |

## Verification
Master transfers run with random transmit and receive bytes drawn from a fixed seed, so every bit lane is covered in both directions. A low slave-select is then applied under three configurations: sensing off, SS as output, and SS as input. Only the third may drop the block out of master mode. Further directed cases check the following:
- a fault in the middle of a byte, which must leave the earlier received byte in place;
- a fault in the same cycle as a flag clear, which shows the fault takes priority;
- the global enable turned on and off while the flag is set;
- a data write in slave mode followed by an externally clocked byte, which shows the written byte really became slave transmit data.

// File: rtl/spi_mf_pkg.sv
package spi_mf_pkg;
    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_STAT = 2'd1;
    localparam logic [1:0] ADDR_DATA = 2'd2;

    localparam int CB_MST   = 0;
    localparam int CB_SSOFF = 1;
    localparam int CB_SSOUT = 2;
    localparam int CB_IE    = 3;

    localparam int SB_FLAG  = 0;
    localparam int SB_BUSY  = 1;

    // synchroniser lane order
    localparam int LN_MOSI  = 0;
    localparam int LN_SCK   = 1;
    localparam int LN_SS    = 2;
    localparam int LANES    = 3;
endpackage

// File: rtl/spi_mf_sync.sv
module spi_mf_sync #(
    parameter int                 W       = 3,
    parameter int                 STAGES  = 2,
    parameter logic [W-1:0]       RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [STAGES-1:0][W-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d[0] = d_i;
        for (int i = 1; i < STAGES; i++) begin
            pipe_d[i] = pipe_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= {STAGES{RST_VAL}};
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/spi_mf_shift.sv
module spi_mf_shift #(
    parameter int DW       = 8,
    parameter int DIV_HALF = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          master_i,
    input  logic          start_i,
    input  logic          load_i,
    input  logic          abort_i,
    input  logic [DW-1:0] tx_i,
    input  logic          miso_i,
    input  logic          s_sck_i,
    input  logic          s_mosi_i,
    input  logic          s_sel_i,
    output logic          sck_o,
    output logic          out_bit_o,
    output logic          busy_o,
    output logic [DW-1:0] rx_o
);
    localparam int CW  = $clog2(DW);
    localparam int DVW = $clog2(DIV_HALF + 1);
    localparam logic [CW-1:0]  LAST_BIT = CW'(DW - 1);
    localparam logic [DVW-1:0] DIV_TOP  = DVW'(DIV_HALF - 1);

    typedef struct packed {
        logic [DW-1:0]  sh;
        logic [DW-1:0]  acc;
        logic [DW-1:0]  rxb;
        logic [CW-1:0]  cnt;
        logic [DVW-1:0] div;
        logic           sck;
        logic           busy;
        logic           sck_prev;
    } shift_t;

    shift_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.sck_prev = s_sck_i;
        if (master_i) begin
            if (abort_i) begin
                st_d.busy = 1'b0;
                st_d.sck  = 1'b0;
                st_d.cnt  = '0;
                st_d.div  = '0;
            end else if (st_q.busy) begin
                if (st_q.div == DIV_TOP) begin
                    st_d.div = '0;
                    if (!st_q.sck) begin
                        st_d.sck = 1'b1;
                        st_d.acc = {st_q.acc[DW-2:0], miso_i};
                    end else begin
                        st_d.sck = 1'b0;
                        if (st_q.cnt == LAST_BIT) begin
                            st_d.busy = 1'b0;
                            st_d.cnt  = '0;
                            st_d.rxb  = st_q.acc;
                        end else begin
                            st_d.cnt = st_q.cnt + 1'b1;
                            st_d.sh  = st_q.sh << 1;
                        end
                    end
                end else begin
                    st_d.div = st_q.div + 1'b1;
                end
            end else if (start_i) begin
                st_d.busy = 1'b1;
                st_d.sh   = tx_i;
                st_d.cnt  = '0;
                st_d.div  = '0;
                st_d.sck  = 1'b0;
            end
        end else begin
            st_d.busy = 1'b0;
            st_d.sck  = 1'b0;
            st_d.div  = '0;
            if (!s_sel_i) begin
                st_d.cnt = '0;
            end else if (s_sck_i && !st_q.sck_prev) begin
                st_d.acc = {st_q.acc[DW-2:0], s_mosi_i};
            end else if (!s_sck_i && st_q.sck_prev) begin
                st_d.sh = st_q.sh << 1;
                if (st_q.cnt == LAST_BIT) begin
                    st_d.cnt = '0;
                    st_d.rxb = st_q.acc;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
            if (load_i) begin
                st_d.sh = tx_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sck_o     = st_q.sck;
    assign out_bit_o = st_q.sh[DW-1];
    assign busy_o    = st_q.busy;
    assign rx_o      = st_q.rxb;
endmodule

// File: rtl/spi_mf_mode.sv
module spi_mf_mode
    import spi_mf_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_i,
    input  logic [1:0]    addr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic          ss_s_i,
    input  logic          busy_i,
    output logic          mst_o,
    output logic          ssoff_o,
    output logic          ssout_o,
    output logic          ie_o,
    output logic          flag_o,
    output logic [DW-1:0] tx_o,
    output logic          start_o,
    output logic          load_o,
    output logic          fault_o
);
    typedef struct packed {
        logic          mst;
        logic          ssoff;
        logic          ssout;
        logic          ie;
        logic          flag;
        logic [DW-1:0] tx;
    } mode_t;

    mode_t md_d, md_q;
    logic  fault, wr_ctrl, wr_stat, wr_data;

    assign wr_ctrl = wr_i && (addr_i == ADDR_CTRL);
    assign wr_stat = wr_i && (addr_i == ADDR_STAT);
    assign wr_data = wr_i && (addr_i == ADDR_DATA);
    assign fault   = md_q.mst && !md_q.ssoff && !md_q.ssout && !ss_s_i;

    always_comb begin
        md_d = md_q;
        if (wr_ctrl) begin
            md_d.mst   = wdata_i[CB_MST];
            md_d.ssoff = wdata_i[CB_SSOFF];
            md_d.ssout = wdata_i[CB_SSOUT];
            md_d.ie    = wdata_i[CB_IE];
        end
        if (wr_stat && wdata_i[SB_FLAG]) begin
            md_d.flag = 1'b0;
        end
        if (wr_data) begin
            md_d.tx = wdata_i;
        end
        if (fault) begin
            md_d.mst  = 1'b0;
            md_d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            md_q <= '0;
        end else begin
            md_q <= md_d;
        end
    end

    assign mst_o   = md_q.mst;
    assign ssoff_o = md_q.ssoff;
    assign ssout_o = md_q.ssout;
    assign ie_o    = md_q.ie;
    assign flag_o  = md_q.flag;
    assign tx_o    = wdata_i;
    assign start_o = wr_data && md_q.mst && !fault && !busy_i;
    assign load_o  = wr_data && !md_q.mst;
    assign fault_o = fault;
endmodule

// File: rtl/spi_mf_ctrl.sv
module spi_mf_ctrl
    import spi_mf_pkg::*;
#(
    parameter int DW          = 8,
    parameter int DIV_HALF    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr_i,
    input  logic [1:0]    reg_addr_i,
    input  logic [DW-1:0] reg_wdata_i,
    output logic [DW-1:0] reg_rdata_o,
    input  logic          gie_i,
    output logic          irq_o,
    input  logic          sck_i,
    output logic          sck_o,
    output logic          sck_oe_o,
    input  logic          mosi_i,
    output logic          mosi_o,
    output logic          mosi_oe_o,
    input  logic          miso_i,
    output logic          miso_o,
    output logic          miso_oe_o,
    input  logic          ss_i
);
    localparam logic [LANES-1:0] SYNC_RST = LANES'(1) << LN_SS;

    logic [LANES-1:0] pins_s;
    logic             ss_s, mst, ssoff, ssout, ie, flag;
    logic             start, load, fault, busy, out_bit;
    logic [DW-1:0]    tx, rx;

    spi_mf_sync #(.W(LANES), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({ss_i, sck_i, mosi_i}),
        .q_o   (pins_s)
    );

    assign ss_s = pins_s[LN_SS];

    spi_mf_mode #(.DW(DW)) mode_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (reg_wr_i),
        .addr_i  (reg_addr_i),
        .wdata_i (reg_wdata_i),
        .ss_s_i  (ss_s),
        .busy_i  (busy),
        .mst_o   (mst),
        .ssoff_o (ssoff),
        .ssout_o (ssout),
        .ie_o    (ie),
        .flag_o  (flag),
        .tx_o    (tx),
        .start_o (start),
        .load_o  (load),
        .fault_o (fault)
    );

    spi_mf_shift #(.DW(DW), .DIV_HALF(DIV_HALF)) shift_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .master_i  (mst),
        .start_i   (start),
        .load_i    (load),
        .abort_i   (fault),
        .tx_i      (tx),
        .miso_i    (miso_i),
        .s_sck_i   (pins_s[LN_SCK]),
        .s_mosi_i  (pins_s[LN_MOSI]),
        .s_sel_i   (!ss_s),
        .sck_o     (sck_o),
        .out_bit_o (out_bit),
        .busy_o    (busy),
        .rx_o      (rx)
    );

    always_comb begin
        reg_rdata_o = '0;
        case (reg_addr_i)
            ADDR_CTRL: begin
                reg_rdata_o[CB_MST]   = mst;
                reg_rdata_o[CB_SSOFF] = ssoff;
                reg_rdata_o[CB_SSOUT] = ssout;
                reg_rdata_o[CB_IE]    = ie;
            end
            ADDR_STAT: begin
                reg_rdata_o[SB_FLAG] = flag;
                reg_rdata_o[SB_BUSY] = busy;
            end
            ADDR_DATA: reg_rdata_o = rx;
            default:   reg_rdata_o = '0;
        endcase
    end

    assign irq_o     = flag && ie && gie_i;
    assign mosi_o    = out_bit;
    assign miso_o    = out_bit;
    assign sck_oe_o  = mst;
    assign mosi_oe_o = mst;
    assign miso_oe_o = !mst;
endmodule

// File: rtl/spi_mf_ctrl_chk.sv
module spi_mf_ctrl_chk
    import spi_mf_pkg::*;
#(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          reg_wr_i,
    input logic [1:0]    reg_addr_i,
    input logic [DW-1:0] reg_wdata_i,
    input logic          gie_i,
    input logic          irq_o,
    input logic          sck_o,
    input logic          sck_oe_o,
    input logic          mosi_oe_o,
    input logic          miso_oe_o,
    input logic          mst,
    input logic          ssoff,
    input logic          ssout,
    input logic          flag,
    input logic          ss_s,
    input logic          busy
);
    logic ctrl_wr, clr_wr, fault_cond;
    assign ctrl_wr    = reg_wr_i && (reg_addr_i == ADDR_CTRL);
    assign clr_wr     = reg_wr_i && (reg_addr_i == ADDR_STAT) && reg_wdata_i[SB_FLAG];
    assign fault_cond = mst && !ssoff && !ssout && !ss_s;

    a_r3_ssoff_keeps_master: assert property (@(posedge clk) disable iff (!rst_n)
        (mst && ssoff && !ctrl_wr) |=> mst);

    a_r7_ssout_keeps_master: assert property (@(posedge clk) disable iff (!rst_n)
        (mst && ssout && !ctrl_wr) |=> mst);

    a_r5_fault_drops_master: assert property (@(posedge clk) disable iff (!rst_n)
        fault_cond |=> (!mst && flag));

    a_r9_no_auto_return: assert property (@(posedge clk) disable iff (!rst_n)
        (!mst && !ctrl_wr) |=> !mst);

    a_r6_irq_needs_all: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (gie_i && flag));

    a_r10_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mst) |-> (!busy && !sck_o));

    a_r8_slave_pins: assert property (@(posedge clk) disable iff (!rst_n)
        !mst |-> (!sck_oe_o && !mosi_oe_o && miso_oe_o));

    a_r11_fault_wins_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_cond && clr_wr) |=> flag);

    a_r12_no_slave_burst: assert property (@(posedge clk) disable iff (!rst_n)
        !mst |=> (!busy && !sck_o));
endmodule

bind spi_mf_ctrl spi_mf_ctrl_chk #(.DW(DW)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr_i    (reg_wr_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .gie_i       (gie_i),
    .irq_o       (irq_o),
    .sck_o       (sck_o),
    .sck_oe_o    (sck_oe_o),
    .mosi_oe_o   (mosi_oe_o),
    .miso_oe_o   (miso_oe_o),
    .mst         (mst),
    .ssoff       (ssoff),
    .ssout       (ssout),
    .flag        (flag),
    .ss_s        (ss_s),
    .busy        (busy)
);

// File: tb/spi_mf_ctrl_tb.sv
module spi_mf_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       gie = 1'b0;
    logic       irq;
    logic       sck_i = 1'b0, sck_o, sck_oe;
    logic       mosi_i = 1'b0, mosi_o, mosi_oe;
    logic       miso_i = 1'b0, miso_o, miso_oe;
    logic       ss_i = 1'b1;

    int n_chk = 0;
    int n_fail = 0;

    logic [7:0] sl_byte = 8'h00;
    int         sl_idx  = 7;
    logic [7:0] cap     = 8'h00;

    always #5 clk = ~clk;

    spi_mf_ctrl dut_i (
        .clk(clk), .rst_n(rst_n),
        .reg_wr_i(reg_wr), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
        .reg_rdata_o(reg_rdata), .gie_i(gie), .irq_o(irq),
        .sck_i(sck_i), .sck_o(sck_o), .sck_oe_o(sck_oe),
        .mosi_i(mosi_i), .mosi_o(mosi_o), .mosi_oe_o(mosi_oe),
        .miso_i(miso_i), .miso_o(miso_o), .miso_oe_o(miso_oe),
        .ss_i(ss_i)
    );

    // external slave model for master transfers
    always @(negedge sck_o) begin
        if (sl_idx >= 0) begin
            miso_i = sl_byte[sl_idx];
            sl_idx = sl_idx - 1;
        end
    end
    always @(posedge sck_o) cap = {cap[6:0], mosi_o};

    function automatic logic exp_irq(input logic f, input logic ie, input logic g);
        return f & ie & g;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_idle();
        logic [7:0] s;
        for (int i = 0; i < 200; i++) begin
            rd(2'd1, s);
            if (!s[1]) break;
        end
    endtask

    task automatic master_xfer(input logic [7:0] tx, input logic [7:0] sl, output logic [7:0] rx);
        sl_byte = sl; miso_i = sl[7]; sl_idx = 6; cap = 8'h00;
        wr(2'd2, tx);
        wait_idle();
        rd(2'd2, rx);
    endtask

    task automatic slave_byte(input logic [7:0] m, output logic [7:0] got);
        got = 8'h00;
        for (int i = 7; i >= 0; i--) begin
            mosi_i = m[i];
            idle(6);
            got = {got[6:0], miso_o};
            sck_i = 1'b1;
            idle(6);
            sck_i = 1'b0;
            idle(6);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(10 * 150000);
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [7:0] d, rx, tx, sl, last_rx, got;
        void'($urandom(32'h1234_5eed));
        idle(3);
        // R1 reset state
        rd(2'd0, d); check("R1 ctrl", d, 0);
        rd(2'd1, d); check("R1 stat", d, 0);
        check("R1 sck_oe", sck_oe, 0);
        check("R1 mosi_oe", mosi_oe, 0);
        check("R1 irq", irq, 0);
        rst_n = 1'b1;
        idle(2);
        rd(2'd0, d); check("R1 ctrl after release", d, 0);

        // master on, sensing on, SS input, ie on
        wr(2'd0, 8'h09);
        idle(4);
        rd(2'd0, d); check("R4 master kept with ss high", d, 8'h09);
        check("R8 master sck_oe", sck_oe, 1);
        check("R8 master mosi_oe", mosi_oe, 1);
        check("R8 master miso_oe", miso_oe, 0);

        // R2 random transfers
        master_xfer(8'hA5, 8'h3C, rx);
        check("R2 directed rx", rx, 8'h3C);
        check("R2 directed mosi", cap, 8'hA5);
        for (int k = 0; k < 16; k++) begin
            tx = 8'($urandom); sl = 8'($urandom);
            master_xfer(tx, sl, rx);
            check("R2 random rx", rx, sl);
            check("R2 random mosi", cap, tx);
            last_rx = rx;
        end
        rd(2'd0, d); check("R4 master after transfers", d, 8'h09);

        // R3 sensing off: SS low ignored
        wr(2'd0, 8'h03);
        ss_i = 1'b0;
        idle(20);
        rd(2'd0, d); check("R3 master kept", d, 8'h03);
        rd(2'd1, d); check("R3 no flag", d, 0);
        // R7 SS as output: SS low ignored
        wr(2'd0, 8'h05);
        idle(20);
        rd(2'd0, d); check("R7 master kept", d, 8'h05);
        rd(2'd1, d); check("R7 no flag", d, 0);
        master_xfer(8'h5A, 8'hC3, rx);
        check("R7 transfer with ss low", rx, 8'hC3);
        last_rx = rx;
        ss_i = 1'b1;
        idle(4);

        // R5 fault
        wr(2'd0, 8'h09);
        gie = 1'b1;
        idle(2);
        ss_i = 1'b0;
        idle(4);
        rd(2'd0, d); check("R5 master cleared", d, 8'h08);
        rd(2'd1, d); check("R5 flag set", d, 8'h01);
        check("R6 irq gie on", irq, exp_irq(1, 1, 1));
        gie = 1'b0; #1;
        check("R6 irq gie off", irq, exp_irq(1, 1, 0));
        gie = 1'b1;
        check("R8 slave sck_oe", sck_oe, 0);
        check("R8 slave mosi_oe", mosi_oe, 0);
        check("R8 slave miso_oe", miso_oe, 1);
        ss_i = 1'b1;
        idle(30);
        rd(2'd0, d); check("R9 still slave", d, 8'h08);

        // R12 slave write: no burst, then externally clocked byte
        wr(2'd2, 8'hB6);
        idle(20);
        check("R12 no sck", sck_o, 0);
        rd(2'd1, d); check("R12 not busy", d[1], 0);
        ss_i = 1'b0;
        idle(4);
        slave_byte(8'h6D, got);
        check("R12 slave miso", got, 8'hB6);
        rd(2'd2, d); check("R12 slave rx", d, 8'h6D);
        ss_i = 1'b1;
        idle(4);

        // R11 clear
        wr(2'd1, 8'h01);
        rd(2'd1, d); check("R11 flag cleared", d, 0);
        check("R6 irq after clear", irq, exp_irq(0, 1, 1));

        // R9 rewrite restores master
        wr(2'd0, 8'h09);
        idle(2);
        rd(2'd0, d); check("R9 master restored", d, 8'h09);
        master_xfer(8'h81, 8'h7E, rx);
        check("R2 after restore", rx, 8'h7E);
        last_rx = rx;

        // R10 mid-byte fault
        sl_byte = 8'hFF; miso_i = 1'b1; sl_idx = 6;
        wr(2'd2, 8'h33);
        idle(10);
        ss_i = 1'b0;
        idle(4);
        check("R10 sck low", sck_o, 0);
        check("R10 sck released", sck_oe, 0);
        rd(2'd1, d); check("R10 not busy", d[1], 0);
        rd(2'd2, d); check("R10 rx kept", d, last_rx);
        ss_i = 1'b1;
        idle(4);

        // R11 fault in the same cycle as clear
        wr(2'd0, 8'h09);
        idle(4);
        @(negedge clk);
        ss_i = 1'b0;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = 8'h01;
        @(negedge clk);
        reg_wr = 1'b0;
        rd(2'd1, d); check("R11 fault wins", d[0], 1);
        rd(2'd0, d); check("R5 master cleared again", d[0], 0);
        ss_i = 1'b1;
        idle(4);

        finish_run();
    end
endmodule